// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block governs a port of sixteen general-purpose pins from a small memory-mapped register file. For every pin, software chooses one of four modes (plain input, software-driven output, peripheral-driven output, or analog), an output type (push-pull or open-drain) and a weak pull selection. From these settings the block computes four pad-control signals per pin: drive enable, drive level, pull-up enable and pull-down enable.

In peripheral-driven mode a per-pin 4-bit selector picks one of sixteen peripheral enable/data pairs. Pad levels are captured into an input data register every clock, except in analog mode, where the captured bit is held at zero. A separate set/clear register changes single output bits in one write, with no read-modify-write.

Writes take a word index, 32-bit data and four byte strobes, so 8-bit, 16-bit and 32-bit stores all work. Reads are registered and return data one cycle after the address is presented. Pad outputs are also registered, so they follow a register write by one clock.

Top module: `pinport_ctrl`

## Requirements
- R1: After synchronous reset every register is zero, so each pin is in input mode with no pull, and pad_oe, pad_do, pad_pu and pad_pd are all zero.
- R2: Word offsets are mode=0 (2 bits per pin at bits 2n+1:2n; 00 input, 01 output, 10 alternate, 11 analog), otype=1 (bit n, 1 = open-drain), pull=2 (bits 2n+1:2n; 01 up, 10 down, 00 and 11 none), input data=3 (read-only), output data=4, set/clear=5, alternate low=6, alternate high=7. rd_data holds the register at rd_addr one cycle later. Unmapped offsets and otype bits 31:16 read zero.
- R3: A write changes only the bytes whose wr_strb bit is 1. Byte b covers data bits 8b+7:8b.
- R4: A set/clear write sets output bit n where data bit n is 1 and clears it where data bit n+16 is 1. Zero bits, and bits in bytes whose strobe is 0, have no effect. Set wins if both bits are 1. The register reads zero.
- R5: A push-pull pin in output mode drives pad_oe=1 with pad_do equal to its output data bit. In alternate mode it passes the selected peripheral's enable and data unchanged.
- R6: An open-drain pin drives pad_do=0. pad_oe is 1 only when the source enables the pin with data 0, so a 1 releases the pin.
- R7: In input and analog modes pad_oe and pad_do are 0.
- R8: pad_pu and pad_pd follow the pin's pull field in input, output and alternate modes, and are both 0 in analog mode.
- R9: Input data bit n is the pad level sampled on the previous clock, or 0 when pin n is analog. The output data register reads back the written value, not the pad level.
- R10: In alternate mode, pin n uses selector field n: pins 0-7 take bits 4n+3:4n of the low register, and pins 8-15 take bits 4(n-8)+3:4(n-8) of the high register. The selector picks index 16n+sel of af_oe and af_do.
- R11: Pad outputs change on the clock after the register write that affects them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request this cycle |
| wr_addr | input | 4 | Word offset of the write |
| wr_strb | input | 4 | Byte write strobes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Word offset to read |
| rd_data | output | 32 | Registered read data |
| af_oe | input | 256 | Peripheral enables, index 16*pin+function |
| af_do | input | 256 | Peripheral data, index 16*pin+function |
| pad_in | input | 16 | Pad levels |
| pad_oe | output | 16 | Pad drive enable |
| pad_do | output | 16 | Pad drive level |
| pad_pu | output | 16 | Weak pull-up enable |
| pad_pd | output | 16 | Weak pull-down enable |

## Verification
The assertions assume that wr_addr, wr_strb and rd_addr are valid, known values whenever they are sampled, and that pad_in and the peripheral buses settle between clocks. The pad properties also assume that mode and output type change only through the register interface, so the settings seen one cycle earlier are the ones the pad stage used. The bench drives every input at the falling edge and changes configuration only through whole write transactions, which keeps the stimulus within these assumptions.

// File: rtl/pinport_pkg.sv
package pinport_pkg;
  typedef enum logic [1:0] {
    PM_IN  = 2'b00,
    PM_OUT = 2'b01,
    PM_ALT = 2'b10,
    PM_ANA = 2'b11
  } pin_mode_e;

  localparam int unsigned OFS_MODE   = 0;
  localparam int unsigned OFS_OTYPE  = 1;
  localparam int unsigned OFS_PULL   = 2;
  localparam int unsigned OFS_IDR    = 3;
  localparam int unsigned OFS_ODR    = 4;
  localparam int unsigned OFS_SETCLR = 5;
  localparam int unsigned OFS_AFLO   = 6;
  localparam int unsigned OFS_AFHI   = 7;

  localparam logic [1:0] PULL_UP = 2'b01;
  localparam logic [1:0] PULL_DN = 2'b10;
endpackage

// File: rtl/pinport_regs.sv
module pinport_regs import pinport_pkg::*; #(
  parameter int NPINS  = 16,
  parameter int DW     = 32,
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DW/8-1:0]      wr_strb,
  input  logic [DW-1:0]        wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [NPINS-1:0]     idr_i,
  output logic [DW-1:0]        mode_o,
  output logic [NPINS-1:0]     otype_o,
  output logic [DW-1:0]        pull_o,
  output logic [NPINS-1:0]     odr_o,
  output logic [2*DW-1:0]      afsel_o,
  output logic [DW-1:0]        rd_data_o
);
  localparam int NB = DW / 8;
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_OTYPE  = ADDR_W'(OFS_OTYPE);
  localparam logic [ADDR_W-1:0] A_PULL   = ADDR_W'(OFS_PULL);
  localparam logic [ADDR_W-1:0] A_IDR    = ADDR_W'(OFS_IDR);
  localparam logic [ADDR_W-1:0] A_ODR    = ADDR_W'(OFS_ODR);
  localparam logic [ADDR_W-1:0] A_SETCLR = ADDR_W'(OFS_SETCLR);
  localparam logic [ADDR_W-1:0] A_AFLO   = ADDR_W'(OFS_AFLO);
  localparam logic [ADDR_W-1:0] A_AFHI   = ADDR_W'(OFS_AFHI);

  logic [DW-1:0]    mode_q, pull_q, aflo_q, afhi_q;
  logic [NPINS-1:0] otype_q, odr_q;
  logic [DW-1:0]    bmask;
  logic [NPINS-1:0] set_bits, clr_bits;

  // expand byte strobes into a bit mask
  always_comb begin
    for (int b = 0; b < NB; b++) bmask[b*8 +: 8] = {8{wr_strb[b]}};
  end

  assign set_bits = wr_data[NPINS-1:0]       & bmask[NPINS-1:0];
  assign clr_bits = wr_data[2*NPINS-1:NPINS] & bmask[2*NPINS-1:NPINS];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      pull_q  <= '0;
      aflo_q  <= '0;
      afhi_q  <= '0;
      otype_q <= '0;
      odr_q   <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_MODE:   mode_q  <= (mode_q & ~bmask) | (wr_data & bmask);
        A_PULL:   pull_q  <= (pull_q & ~bmask) | (wr_data & bmask);
        A_AFLO:   aflo_q  <= (aflo_q & ~bmask) | (wr_data & bmask);
        A_AFHI:   afhi_q  <= (afhi_q & ~bmask) | (wr_data & bmask);
        A_OTYPE:  otype_q <= (otype_q & ~bmask[NPINS-1:0]) | (wr_data[NPINS-1:0] & bmask[NPINS-1:0]);
        A_ODR:    odr_q   <= (odr_q & ~bmask[NPINS-1:0]) | (wr_data[NPINS-1:0] & bmask[NPINS-1:0]);
        A_SETCLR: odr_q   <= (odr_q & ~clr_bits) | set_bits;  // set wins
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else begin
      unique case (rd_addr)
        A_MODE:  rd_data_o <= mode_q;
        A_OTYPE: rd_data_o <= DW'(otype_q);
        A_PULL:  rd_data_o <= pull_q;
        A_IDR:   rd_data_o <= DW'(idr_i);
        A_ODR:   rd_data_o <= DW'(odr_q);
        A_AFLO:  rd_data_o <= aflo_q;
        A_AFHI:  rd_data_o <= afhi_q;
        default: rd_data_o <= '0;
      endcase
    end
  end

  assign mode_o  = mode_q;
  assign otype_o = otype_q;
  assign pull_o  = pull_q;
  assign odr_o   = odr_q;
  assign afsel_o = {afhi_q, aflo_q};
endmodule

// File: rtl/pinport_pad.sv
module pinport_pad import pinport_pkg::*; #(
  parameter int NAF  = 16,
  parameter int SELW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      mode_i,
  input  logic            otype_i,
  input  logic [1:0]      pull_i,
  input  logic            odr_i,
  input  logic [SELW-1:0] afsel_i,
  input  logic [NAF-1:0]  af_oe_i,
  input  logic [NAF-1:0]  af_do_i,
  input  logic            pad_in_i,
  output logic            oe_o,
  output logic            do_o,
  output logic            pu_o,
  output logic            pd_o,
  output logic            idr_o
);
  pin_mode_e mode;
  logic src_oe, src_do, drv_oe, drv_do, analog;

  assign mode   = pin_mode_e'(mode_i);
  assign analog = (mode == PM_ANA);

  always_comb begin
    unique case (mode)
      PM_OUT: begin src_oe = 1'b1;              src_do = odr_i;              end
      PM_ALT: begin src_oe = af_oe_i[afsel_i];  src_do = af_do_i[afsel_i];  end
      default: begin src_oe = 1'b0;             src_do = 1'b0;               end
    endcase
  end

  // open-drain: only a driven 0 enables the pad
  assign drv_oe = otype_i ? (src_oe & ~src_do) : src_oe;
  assign drv_do = otype_i ? 1'b0 : src_do;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_o  <= 1'b0;
      do_o  <= 1'b0;
      pu_o  <= 1'b0;
      pd_o  <= 1'b0;
      idr_o <= 1'b0;
    end else begin
      oe_o  <= drv_oe;
      do_o  <= drv_do;
      pu_o  <= !analog && (pull_i == PULL_UP);
      pd_o  <= !analog && (pull_i == PULL_DN);
      idr_o <= !analog && pad_in_i;
    end
  end
endmodule

// File: rtl/pinport_ctrl.sv
module pinport_ctrl import pinport_pkg::*; #(
  parameter int NPINS  = 16,
  parameter int NAF    = 16,
  parameter int DW     = 32,
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DW/8-1:0]      wr_strb,
  input  logic [DW-1:0]        wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DW-1:0]        rd_data,
  input  logic [NPINS*NAF-1:0] af_oe,
  input  logic [NPINS*NAF-1:0] af_do,
  input  logic [NPINS-1:0]     pad_in,
  output logic [NPINS-1:0]     pad_oe,
  output logic [NPINS-1:0]     pad_do,
  output logic [NPINS-1:0]     pad_pu,
  output logic [NPINS-1:0]     pad_pd
);
  localparam int SELW = $clog2(NAF);

  logic [DW-1:0]    mode_w, pull_w;
  logic [NPINS-1:0] otype_w, odr_w, idr_w;
  logic [2*DW-1:0]  afsel_w;

  pinport_regs #(.NPINS(NPINS), .DW(DW), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_strb(wr_strb), .wr_data(wr_data),
    .rd_addr(rd_addr), .idr_i(idr_w),
    .mode_o(mode_w), .otype_o(otype_w), .pull_o(pull_w), .odr_o(odr_w),
    .afsel_o(afsel_w), .rd_data_o(rd_data)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pinport_pad #(.NAF(NAF), .SELW(SELW)) u_pad (
      .clk(clk), .rst(rst),
      .mode_i(mode_w[2*i +: 2]), .otype_i(otype_w[i]), .pull_i(pull_w[2*i +: 2]),
      .odr_i(odr_w[i]), .afsel_i(afsel_w[i*SELW +: SELW]),
      .af_oe_i(af_oe[i*NAF +: NAF]), .af_do_i(af_do[i*NAF +: NAF]),
      .pad_in_i(pad_in[i]),
      .oe_o(pad_oe[i]), .do_o(pad_do[i]), .pu_o(pad_pu[i]), .pd_o(pad_pd[i]),
      .idr_o(idr_w[i])
    );
  end
endmodule

// File: rtl/pinport_chk.sv
module pinport_chk import pinport_pkg::*; #(
  parameter int NPINS  = 16,
  parameter int DW     = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [DW-1:0]     mode,
  input logic [NPINS-1:0]  otype,
  input logic [NPINS-1:0]  idr,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_do,
  input logic [NPINS-1:0]  pad_pu,
  input logic [NPINS-1:0]  pad_pd,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DW-1:0]     rd_data
);
  // R4: set/clear register always reads zero
  a_r4_setclr_reads_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rd_addr) == ADDR_W'(OFS_SETCLR) |-> rd_data == '0);

  // R2: offsets beyond the map read zero
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rd_addr) > ADDR_W'(OFS_AFHI) |-> rd_data == '0);

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    // R7: no drive in input or analog mode
    a_r7_no_drive: assert property (@(posedge clk) disable iff (rst)
      ($past(mode[2*i +: 2]) == PM_IN || $past(mode[2*i +: 2]) == PM_ANA)
        |-> (!pad_oe[i] && !pad_do[i]));

    // R6: open-drain never drives high
    a_r6_od_never_high: assert property (@(posedge clk) disable iff (rst)
      $past(otype[i]) |-> !pad_do[i]);

    // R5: push-pull output mode always enables the driver
    a_r5_pp_out_drives: assert property (@(posedge clk) disable iff (rst)
      ($past(mode[2*i +: 2]) == PM_OUT && !$past(otype[i])) |-> pad_oe[i]);

    // R8: pulls exclusive and off in analog mode
    a_r8_pull_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(pad_pu[i] && pad_pd[i]));
    a_r8_analog_no_pull: assert property (@(posedge clk) disable iff (rst)
      $past(mode[2*i +: 2]) == PM_ANA |-> (!pad_pu[i] && !pad_pd[i]));

    // R9: analog pins sample zero
    a_r9_analog_idr_zero: assert property (@(posedge clk) disable iff (rst)
      $past(mode[2*i +: 2]) == PM_ANA |-> !idr[i]);
  end
endmodule

bind pinport_ctrl pinport_chk #(.NPINS(NPINS), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode_w), .otype(otype_w), .idr(idr_w),
  .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu), .pad_pd(pad_pd),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/pinport_ctrl_bench.sv
module pinport_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 16;
  localparam int NAF = 16;
  localparam logic [3:0] A_MODE = 4'd0, A_OTYPE = 4'd1, A_PULL = 4'd2, A_IDR = 4'd3,
                         A_ODR = 4'd4, A_SETCLR = 4'd5, A_AFLO = 4'd6, A_AFHI = 4'd7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [3:0] wr_strb = '0;
  logic [31:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [NPINS*NAF-1:0] af_oe = '0, af_do = '0;
  logic [NPINS-1:0] pad_in = '0;
  logic [NPINS-1:0] pad_oe, pad_do, pad_pu, pad_pd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinport_ctrl u_pinport_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_strb(wr_strb),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .af_oe(af_oe), .af_do(af_do), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  typedef struct packed {
    logic [1:0] m; logic ot; logic [1:0] pl; logic od; logic [3:0] sel;
    logic aoe; logic ado; logic pin;
    logic eoe; logic edo; logic epu; logic epd; logic eidr;
  } vec_t;

  // pin 3 configurations and expected pad outputs
  localparam vec_t VEC [13] = '{
    '{2'b00,1'b0,2'b01,1'b0,4'd0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b1,1'b0,1'b1},
    '{2'b00,1'b0,2'b10,1'b0,4'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,1'b0},
    '{2'b01,1'b0,2'b00,1'b1,4'd0,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b0,1'b0,1'b1},
    '{2'b01,1'b0,2'b00,1'b0,4'd0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0},
    '{2'b01,1'b1,2'b01,1'b1,4'd0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b1,1'b0,1'b1},
    '{2'b01,1'b1,2'b00,1'b0,4'd0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0},
    '{2'b10,1'b0,2'b00,1'b0,4'd7,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b0,1'b0,1'b1},
    '{2'b10,1'b1,2'b00,1'b0,4'd9,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0},
    '{2'b10,1'b1,2'b00,1'b0,4'd9,1'b1,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b1},
    '{2'b10,1'b0,2'b00,1'b1,4'd2,1'b0,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b0,1'b1},
    '{2'b11,1'b0,2'b01,1'b1,4'd0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0},
    '{2'b00,1'b0,2'b11,1'b0,4'd0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b1},
    '{2'b01,1'b0,2'b00,1'b1,4'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_strb = s;
    @(negedge clk);
    wr_en = 1'b0; wr_strb = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 pad_oe", 32'(pad_oe), 32'h0);
    check("R1 pulls", {pad_pu, pad_pd}, 32'h0);
    rd(A_MODE, r); check("R1 mode reg", r, 32'h0);
    rd(A_ODR, r);  check("R1 odr reg", r, 32'h0);

    // vector walk on pin 3: R5 R6 R7 R8 R9 R10 R11
    for (int v = 0; v < 13; v++) begin
      af_oe = '0; af_do = '0;
      af_oe[3*NAF + int'(VEC[v].sel)] = VEC[v].aoe;
      af_do[3*NAF + int'(VEC[v].sel)] = VEC[v].ado;
      pad_in = 16'(VEC[v].pin) << 3;
      wr(A_MODE,  32'(VEC[v].m)   << 6,  4'hF);
      wr(A_OTYPE, 32'(VEC[v].ot)  << 3,  4'hF);
      wr(A_PULL,  32'(VEC[v].pl)  << 6,  4'hF);
      wr(A_ODR,   32'(VEC[v].od)  << 3,  4'hF);
      wr(A_AFLO,  32'(VEC[v].sel) << 12, 4'hF);
      @(negedge clk);
      check($sformatf("R5/R6/R7 vec%0d oe", v), 32'(pad_oe[3]), 32'(VEC[v].eoe));
      check($sformatf("R5/R6/R7 vec%0d do", v), 32'(pad_do[3]), 32'(VEC[v].edo));
      check($sformatf("R8 vec%0d pu", v), 32'(pad_pu[3]), 32'(VEC[v].epu));
      check($sformatf("R8 vec%0d pd", v), 32'(pad_pd[3]), 32'(VEC[v].epd));
      rd(A_IDR, r);
      check($sformatf("R9 vec%0d idr", v), 32'(r[3]), 32'(VEC[v].eidr));
    end

    // R9: output data reads written value, not pad level (pin3 drives 1, pad low)
    rd(A_ODR, r); check("R9 odr readback", r, 32'h0000_0008);

    // R11: pad follows write one clock later
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_ODR; wr_data = 32'h0; wr_strb = 4'hF;
    @(negedge clk);
    wr_en = 1'b0; wr_strb = '0;
    check("R11 before update", 32'(pad_do[3]), 32'h1);
    @(negedge clk);
    check("R11 after update", 32'(pad_do[3]), 32'h0);

    // R3: byte strobes
    wr(A_ODR, 32'hFFFF_FFFF, 4'b0001); rd(A_ODR, r); check("R3 low byte", r, 32'h0000_00FF);
    wr(A_ODR, 32'h0000_AB00, 4'b0010); rd(A_ODR, r); check("R3 second byte", r, 32'h0000_ABFF);
    wr(A_ODR, 32'h0000_0000, 4'b1100); rd(A_ODR, r); check("R3 strobed off", r, 32'h0000_ABFF);

    // R4: set/clear
    wr(A_SETCLR, 32'h00FF_0400, 4'hF); rd(A_ODR, r); check("R4 set and clear", r, 32'h0000_AF00);
    wr(A_SETCLR, 32'h1000_1000, 4'hF); rd(A_ODR, r); check("R4 set wins", r, 32'h0000_BF00);
    rd(A_SETCLR, r); check("R4 reads zero", r, 32'h0);
    wr(A_SETCLR, 32'hFFFF_FFFF, 4'b1100); rd(A_ODR, r); check("R4 clear only", r, 32'h0);
    wr(A_SETCLR, 32'h0000_0180, 4'b0010); rd(A_ODR, r); check("R4 strobe gates set", r, 32'h0000_0100);

    // R2: map details
    rd(4'd9, r); check("R2 unmapped", r, 32'h0);
    wr(A_OTYPE, 32'hFFFF_FFFF, 4'hF); rd(A_OTYPE, r); check("R2 otype width", r, 32'h0000_FFFF);
    wr(A_PULL, 32'hC000_0003, 4'hF);  rd(A_PULL, r);  check("R2 pull readback", r, 32'hC000_0003);
    wr(A_OTYPE, 32'h0, 4'hF);
    wr(A_PULL, 32'h0, 4'hF);

    // R10: pin 12 alternate function from the high selector register
    af_oe = '0; af_do = '0; pad_in = '0;
    af_oe[12*NAF + 5] = 1'b1; af_do[12*NAF + 5] = 1'b1;
    wr(A_MODE, 32'h0200_0000, 4'hF);
    wr(A_AFHI, 32'h0005_0000, 4'hF);
    @(negedge clk);
    check("R10 high sel oe", 32'(pad_oe[12]), 32'h1);
    check("R10 high sel do", 32'(pad_do[12]), 32'h1);
    af_oe = '0; af_do = '0;
    af_oe[12*NAF + 6] = 1'b1; af_do[12*NAF + 6] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R10 unselected oe", 32'(pad_oe[12]), 32'h0);
    check("R10 unselected do", 32'(pad_do[12]), 32'h0);

    finish_run();
  end
endmodule